// File: doc/BRIEF.md
# Byte ALU with Flag Masking and Skip Conditions

This block is the execute stage of a small 8-bit processor. Each accepted operation carries an opcode, two operands, a 3-bit amount (a shift count or a bit index) and the current flag byte. One cycle later the block presents the result, the new flag byte, a write-back enable for the destination register and a skip indication. Each operation class changes only its own subset of the flags. Every other flag bit passes through unchanged.

Conditional branches do not jump. A branch tests one flag and tells the sequencer to suppress the single instruction that follows when the condition fails. Operations enter and leave on a valid/ready pair. A result waits in a one-entry output register until the consumer accepts it. While that register is full and `out_ready` is low, `in_ready` stays low, so back-pressure reaches the producer in the same cycle. With `out_ready` held high the block accepts one operation per cycle.

Flag byte layout:
- bit 0 is zero (Z)
- bit 1 is carry (C)
- bit 2 is overflow (O)
- bit 3 is sign (S)
- bit 4 is interrupt-disable (I)
- bit 5 is branch (B)
- bits 7:6 always leave as 0

Top module: `alu8_core`

## Requirements
- R1: An operation transfers when `in_valid` and `in_ready` are both high. Its outputs appear with `out_valid` high after the next rising edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds steady.
- R2: AND (op 0), OR (op 1) and XOR (op 2) write `opa` op `opb`. They set Z when the result is zero and set S to result bit 7. C and O are unchanged.
- R3: INC (op 3) and DEC (op 4) write `opa`+1 and `opa`-1 modulo 256, and update Z and S. Both C and O are set exactly when the value wraps: 0xff to 0x00 for INC, 0x00 to 0xff for DEC. `opb` is ignored.
- R4: ADD (op 5) and SUB (op 6) write `opa`+`opb` and `opa`-`opb` modulo 256. C is the unsigned carry for ADD and the borrow for SUB. O is the two's-complement overflow. Z and S follow the result.
- R5: CMP (op 7) sets Z, C, O and S exactly as SUB would. It drives `wr_en` low and `result` 0x00.
- R6: SHL (op 8) and SHR (op 9) shift by `amt` (0 to 7) with zero fill. They write the result and update Z and S. C takes the last bit shifted out, and 0 when `amt` is 0. O is unchanged.
- R7: ROL (op 10) and ROR (op 11) rotate by `amt`. They write the result and update Z and S. C is the bit that wrapped last: result bit 0 for ROL and result bit 7 for ROR. C is 0 when `amt` is 0. O is unchanged.
- R8: BIT (op 12) sets Z to bit `amt` of `opa`. All other flags are unchanged, `wr_en` is low and `result` is 0x00.
- R9: SCF (op 13) sets C, CCF (op 14) clears C and COF (op 15) clears O. Nothing else changes and nothing is written.
- R10: Branch opcodes 16 to 25 test flag bit `(op-16)>>1` (Z, C, O, S, I), and an odd opcode inverts the test. `skip` is high and B is set when the test fails. When the test passes, `skip` is low and B is cleared. No other flag changes and nothing is written.
- R11: Every operation passes flag I through and drives flag bits 7:6 to 0. Non-branch operations keep B. Opcodes 26 to 31 change no flag, write nothing and do not skip.
- R12: After reset, `out_valid` is low, `in_ready` is high and the output fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| op_in | input | 5 | Opcode |
| opa | input | WIDTH | First operand (destination value) |
| opb | input | WIDTH | Second operand |
| amt | input | $clog2(WIDTH) | Shift count or bit index |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer accepts result |
| result | output | WIDTH | Value for write-back |
| flags_out | output | 8 | Updated flag byte |
| wr_en | output | 1 | Destination register should be written |
| skip | output | 1 | Next instruction must be suppressed |

## Verification
The properties assume only that a transfer is a cycle with both `in_valid` and `in_ready` high. Inputs are sampled on that cycle alone, so the producer need not hold them steady while stalled. Even so, the stimulus keeps them stable during stalls, because a real producer would. Opcodes are drawn across all 32 codes, including the six undefined ones. Flag inputs are random in all eight bits, so the pass-through and zeroing rules are exercised. The amount is naturally limited to 0..7 by its width.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [4:0] {
    OP_AND = 5'd0,  OP_OR  = 5'd1,  OP_XOR = 5'd2,  OP_INC = 5'd3,
    OP_DEC = 5'd4,  OP_ADD = 5'd5,  OP_SUB = 5'd6,  OP_CMP = 5'd7,
    OP_SHL = 5'd8,  OP_SHR = 5'd9,  OP_ROL = 5'd10, OP_ROR = 5'd11,
    OP_BIT = 5'd12, OP_SCF = 5'd13, OP_CCF = 5'd14, OP_COF = 5'd15,
    OP_BZ  = 5'd16, OP_BNZ = 5'd17, OP_BC  = 5'd18, OP_BNC = 5'd19,
    OP_BO  = 5'd20, OP_BNO = 5'd21, OP_BS  = 5'd22, OP_BNS = 5'd23,
    OP_BI  = 5'd24, OP_BNI = 5'd25
  } alu_op_e;

  localparam int FL_Z = 0;
  localparam int FL_C = 1;
  localparam int FL_O = 2;
  localparam int FL_S = 3;
  localparam int FL_I = 4;
  localparam int FL_B = 5;
  localparam logic [7:0] FL_LIVE = 8'h3f;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res,
  output logic             carry,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH:0] ONE = (WIDTH+1)'(1);

  logic [WIDTH:0] wide;

  always_comb begin
    wide  = '0;
    carry = 1'b0;
    ovf   = 1'b0;
    case (op)
      OP_AND: wide = {1'b0, a & b};
      OP_OR:  wide = {1'b0, a | b};
      OP_XOR: wide = {1'b0, a ^ b};
      OP_INC: begin
        wide  = {1'b0, a} + ONE;
        carry = wide[WIDTH];
        ovf   = wide[WIDTH];
      end
      OP_DEC: begin
        wide  = {1'b0, a} - ONE;
        carry = wide[WIDTH];
        ovf   = wide[WIDTH];
      end
      OP_ADD: begin
        wide  = {1'b0, a} + {1'b0, b};
        carry = wide[WIDTH];
        ovf   = (a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]);
      end
      OP_SUB, OP_CMP: begin
        wide  = {1'b0, a} - {1'b0, b};
        carry = wide[WIDTH];
        ovf   = (a[MSB] != b[MSB]) && (wide[MSB] != a[MSB]);
      end
      default: wide = '0;
    endcase
  end

  assign res = wide[WIDTH-1:0];
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH)
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [CW-1:0]    amt,
  output logic [WIDTH-1:0] res,
  output logic             carry
);
  logic [WIDTH-1:0] shl_v [WIDTH];
  logic [WIDTH-1:0] shr_v [WIDTH];
  logic [WIDTH-1:0] rol_v [WIDTH];
  logic [WIDTH-1:0] ror_v [WIDTH];
  logic             shl_c [WIDTH];
  logic             shr_c [WIDTH];

  for (genvar k = 0; k < WIDTH; k++) begin : g_amt
    if (k == 0) begin : g_zero
      assign shl_v[k] = a;
      assign shr_v[k] = a;
      assign rol_v[k] = a;
      assign ror_v[k] = a;
      assign shl_c[k] = 1'b0;
      assign shr_c[k] = 1'b0;
    end else begin : g_nz
      assign shl_v[k] = a << k;
      assign shr_v[k] = a >> k;
      assign rol_v[k] = (a << k) | (a >> (WIDTH - k));
      assign ror_v[k] = (a >> k) | (a << (WIDTH - k));
      assign shl_c[k] = a[WIDTH-k];
      assign shr_c[k] = a[k-1];
    end
  end

  always_comb begin
    res   = '0;
    carry = 1'b0;
    case (op)
      OP_SHL: begin res = shl_v[amt]; carry = shl_c[amt]; end
      OP_SHR: begin res = shr_v[amt]; carry = shr_c[amt]; end
      OP_ROL: begin res = rol_v[amt]; carry = (amt != '0) && rol_v[amt][0]; end
      OP_ROR: begin res = ror_v[amt]; carry = (amt != '0) && ror_v[amt][WIDTH-1]; end
      default: begin res = '0; carry = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu8_cond.sv
module alu8_cond (
  input  logic [4:0] op,
  input  logic [7:0] flags,
  output logic       is_branch,
  output logic       skip
);
  logic [2:0] sel;
  logic       invert;
  logic       pass;

  assign sel       = op[3:1];
  assign invert    = op[0];
  assign is_branch = op[4] && (op[3:1] <= 3'd4);
  assign pass      = flags[sel] ^ invert;
  assign skip      = is_branch && !pass;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [4:0]       op_in,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [CW-1:0]    amt,
  input  logic [7:0]       flags_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] result,
  output logic [7:0]       flags_out,
  output logic             wr_en,
  output logic             skip
);
  alu_op_e          op;
  logic [WIDTH-1:0] ar_res, sh_res, nx_res;
  logic             ar_c, ar_v, sh_c;
  logic             br_is, br_skip;
  logic [7:0]       nx_flags;
  logic             nx_wr, nx_skip;
  logic             take;

  assign op = alu_op_e'(op_in);

  alu8_arith #(.WIDTH(WIDTH)) u_arith (
    .op(op), .a(opa), .b(opb), .res(ar_res), .carry(ar_c), .ovf(ar_v)
  );

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .op(op), .a(opa), .amt(amt), .res(sh_res), .carry(sh_c)
  );

  alu8_cond u_cond (
    .op(op_in), .flags(flags_in), .is_branch(br_is), .skip(br_skip)
  );

  always_comb begin
    nx_flags = flags_in & FL_LIVE;
    nx_res   = '0;
    nx_wr    = 1'b0;
    nx_skip  = 1'b0;
    case (op)
      OP_AND, OP_OR, OP_XOR: begin
        nx_res         = ar_res;
        nx_wr          = 1'b1;
        nx_flags[FL_Z] = (ar_res == '0);
        nx_flags[FL_S] = ar_res[WIDTH-1];
      end
      OP_INC, OP_DEC, OP_ADD, OP_SUB: begin
        nx_res         = ar_res;
        nx_wr          = 1'b1;
        nx_flags[FL_Z] = (ar_res == '0);
        nx_flags[FL_S] = ar_res[WIDTH-1];
        nx_flags[FL_C] = ar_c;
        nx_flags[FL_O] = ar_v;
      end
      OP_CMP: begin
        nx_flags[FL_Z] = (ar_res == '0);
        nx_flags[FL_S] = ar_res[WIDTH-1];
        nx_flags[FL_C] = ar_c;
        nx_flags[FL_O] = ar_v;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        nx_res         = sh_res;
        nx_wr          = 1'b1;
        nx_flags[FL_Z] = (sh_res == '0);
        nx_flags[FL_S] = sh_res[WIDTH-1];
        nx_flags[FL_C] = sh_c;
      end
      OP_BIT: nx_flags[FL_Z] = opa[amt];
      OP_SCF: nx_flags[FL_C] = 1'b1;
      OP_CCF: nx_flags[FL_C] = 1'b0;
      OP_COF: nx_flags[FL_O] = 1'b0;
      default: begin
        if (br_is) begin
          nx_skip        = br_skip;
          nx_flags[FL_B] = br_skip;
        end
      end
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      wr_en     <= 1'b0;
      skip      <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      result    <= nx_res;
      flags_out <= nx_flags;
      wr_en     <= nx_wr;
      skip      <= nx_skip;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [4:0]       op_in,
  input logic [WIDTH-1:0] opa,
  input logic [CW-1:0]    amt,
  input logic [7:0]       flags_in,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] result,
  input logic [7:0]       flags_out,
  input logic             wr_en,
  input logic             skip
);
  logic xfer;
  assign xfer = in_valid && in_ready;

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) &&
      $stable(flags_out) && $stable(wr_en) && $stable(skip)));

  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_logic_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && op_in <= 5'd2) |=> (flags_out[2:1] == $past(flags_in[2:1])));

  p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && op_in == 5'd7) |=> (!wr_en && result == '0));

  p_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && op_in == 5'd12) |=> (flags_out[0] == $past(opa[amt]) && !wr_en));

  p_skip_bf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && skip) |-> flags_out[5]);

  p_nonbranch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !op_in[4]) |=> !skip);

  p_if_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (flags_out[4] == $past(flags_in[4]) && flags_out[7:6] == 2'b00));
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_in(op_in), .opa(opa), .amt(amt), .flags_in(flags_in),
  .out_valid(out_valid), .out_ready(out_ready), .result(result),
  .flags_out(flags_out), .wr_en(wr_en), .skip(skip)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] op_in = '0;
  logic [7:0] opa = '0, opb = '0;
  logic [2:0] amt = '0;
  logic [7:0] flags_in = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] result, flags_out;
  logic       wr_en, skip;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  alu8_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_in(op_in), .opa(opa), .opb(opb), .amt(amt), .flags_in(flags_in),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .flags_out(flags_out), .wr_en(wr_en), .skip(skip)
  );

  function automatic logic [17:0] model(input logic [4:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [2:0] n,
                                        input logic [7:0] fi);
    logic [7:0] r, f;
    logic we, sk, zs;
    logic [8:0] w;
    int idx;
    f = fi & 8'h3f; r = 8'h00; we = 1'b0; sk = 1'b0; zs = 1'b0;
    case (op)
      5'd0: begin r = a & b; we = 1; zs = 1; end
      5'd1: begin r = a | b; we = 1; zs = 1; end
      5'd2: begin r = a ^ b; we = 1; zs = 1; end
      5'd3: begin r = a + 8'd1; we = 1; zs = 1; f[1] = (a == 8'hff); f[2] = (a == 8'hff); end
      5'd4: begin r = a - 8'd1; we = 1; zs = 1; f[1] = (a == 8'h00); f[2] = (a == 8'h00); end
      5'd5: begin
        w = {1'b0, a} + {1'b0, b}; r = w[7:0]; we = 1; zs = 1; f[1] = w[8];
        f[2] = ($signed(a) + $signed(b) > 127) || ($signed(a) + $signed(b) < -128);
      end
      5'd6, 5'd7: begin
        r = a - b; we = (op == 5'd6); zs = 1; f[1] = (a < b);
        f[2] = ($signed(a) - $signed(b) > 127) || ($signed(a) - $signed(b) < -128);
      end
      5'd8: begin r = a << n; we = 1; zs = 1; f[1] = (n != 0) ? a[8 - int'(n)] : 1'b0; end
      5'd9: begin r = a >> n; we = 1; zs = 1; f[1] = (n != 0) ? a[int'(n) - 1] : 1'b0; end
      5'd10: begin
        r = (n == 0) ? a : ((a << n) | (a >> (8 - int'(n)))); we = 1; zs = 1;
        f[1] = (n != 0) && r[0];
      end
      5'd11: begin
        r = (n == 0) ? a : ((a >> n) | (a << (8 - int'(n)))); we = 1; zs = 1;
        f[1] = (n != 0) && r[7];
      end
      5'd12: f[0] = a[n];
      5'd13: f[1] = 1'b1;
      5'd14: f[1] = 1'b0;
      5'd15: f[2] = 1'b0;
      default: begin
        if (op >= 5'd16 && op <= 5'd25) begin
          idx = (int'(op) - 16) / 2;
          sk = !(fi[idx] ^ op[0]);
          f[5] = sk;
        end
      end
    endcase
    if (zs) begin f[0] = (r == 8'h00); f[3] = r[7]; end
    if (!we) r = 8'h00;
    return {r, f, we, sk};
  endfunction

  function automatic string req_of(input logic [4:0] op);
    if (op <= 2) return "R2";
    if (op <= 4) return "R3";
    if (op <= 6) return "R4";
    if (op == 7) return "R5";
    if (op <= 9) return "R6";
    if (op <= 11) return "R7";
    if (op == 12) return "R8";
    if (op <= 15) return "R9";
    if (op <= 25) return "R10";
    return "R11";
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] n, input logic [7:0] fi);
    op_in = op; opa = a; opb = b; amt = n; flags_in = fi; in_valid = 1'b1;
  endtask

  task automatic run_op(input string req, input logic [4:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic [2:0] n, input logic [7:0] fi);
    @(negedge clk);
    drive(op, a, b, n, fi);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {result, flags_out, wr_en, skip}, model(op, a, b, n, fi));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [17:0] first;
    repeat (3) @(negedge clk);
    check("R12", {16'h0, out_valid, in_ready}, {16'h0, 1'b0, 1'b1});
    check("R12", {result, flags_out, wr_en, skip}, 18'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", {17'h0, out_valid}, 18'h0);

    run_op("R3 inc wrap",  5'd3, 8'hff, 8'h55, 3'd0, 8'h00);
    run_op("R3 dec wrap",  5'd4, 8'h00, 8'h00, 3'd0, 8'h00);
    run_op("R3 inc plain", 5'd3, 8'h41, 8'h00, 3'd0, 8'h06);
    run_op("R4 add ovf",   5'd5, 8'h7f, 8'h01, 3'd0, 8'h00);
    run_op("R4 add carry", 5'd5, 8'hff, 8'h01, 3'd0, 8'h00);
    run_op("R4 sub borrow",5'd6, 8'h00, 8'h01, 3'd0, 8'h00);
    run_op("R4 sub ovf",   5'd6, 8'h80, 8'h01, 3'd0, 8'h00);
    run_op("R5 cmp eq",    5'd7, 8'h3c, 8'h3c, 3'd0, 8'h0e);
    run_op("R2 and keeps", 5'd0, 8'hf0, 8'h0f, 3'd0, 8'h06);
    run_op("R6 shl out",   5'd8, 8'h81, 8'h00, 3'd1, 8'h04);
    run_op("R6 shl zero",  5'd8, 8'hff, 8'h00, 3'd0, 8'h02);
    run_op("R6 shr out",   5'd9, 8'h01, 8'h00, 3'd1, 8'h00);
    run_op("R6 shr seven", 5'd9, 8'h80, 8'h00, 3'd7, 8'h00);
    run_op("R7 rol",       5'd10, 8'h80, 8'h00, 3'd1, 8'h00);
    run_op("R7 ror",       5'd11, 8'h01, 8'h00, 3'd1, 8'h00);
    run_op("R7 ror zero",  5'd11, 8'h01, 8'h00, 3'd0, 8'h02);
    run_op("R8 bit set",   5'd12, 8'h20, 8'h00, 3'd5, 8'h0e);
    run_op("R8 bit clr",   5'd12, 8'hdf, 8'h00, 3'd5, 8'h01);
    run_op("R9 scf",       5'd13, 8'h00, 8'h00, 3'd0, 8'h00);
    run_op("R9 ccf",       5'd14, 8'h00, 8'h00, 3'd0, 8'hff);
    run_op("R9 cof",       5'd15, 8'h00, 8'h00, 3'd0, 8'h3f);
    run_op("R10 bz taken", 5'd16, 8'h00, 8'h00, 3'd0, 8'h21);
    run_op("R10 bz skip",  5'd16, 8'h00, 8'h00, 3'd0, 8'h00);
    run_op("R10 bni skip", 5'd25, 8'h00, 8'h00, 3'd0, 8'h10);
    run_op("R11 undef op", 5'd30, 8'h12, 8'h34, 3'd3, 8'hff);

    // R1 back-pressure: result held, input refused until consumer accepts
    @(negedge clk);
    out_ready = 1'b0;
    drive(5'd5, 8'h10, 8'h20, 3'd0, 8'h00);
    @(posedge clk);
    @(negedge clk);
    first = model(5'd5, 8'h10, 8'h20, 3'd0, 8'h00);
    check("R1 stall ready", {17'h0, in_ready}, 18'h0);
    drive(5'd1, 8'h0f, 8'hf0, 3'd0, 8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 stall hold", {result, flags_out, wr_en, skip}, first);
    check("R1 stall valid", {17'h0, out_valid}, 18'h1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 release", {result, flags_out, wr_en, skip}, model(5'd1, 8'h0f, 8'hf0, 3'd0, 8'h00));
    @(posedge clk);
    @(negedge clk);
    check("R1 drain", {17'h0, out_valid}, 18'h0);

    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] rop;
      rop = 5'($urandom_range(0, 31));
      run_op(req_of(rop), rop, 8'($urandom), 8'($urandom), 3'($urandom), 8'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule